// File: doc/BRIEF.md
# Replay FIFO with Saved Read and Write Marks

This block is a single-clock, single-direction FIFO holding 512 words of 18 bits. It differs from a plain FIFO in one way: it keeps a saved copy of each pointer. A saved read position lets a consumer go back and read the same data again, for example to retry a transfer. A saved write position lets a producer discard part of a message it has already written and write it again.

Each saved position is loaded from its live pointer by a capture strobe. A restore strobe copies it back into the live pointer. A clear strobe returns all four pointers to zero. The empty and full flags come straight from the live pointers, so they are correct again in the cycle after any restore. The read port is registered: an accepted read updates the data output at the clock edge that accepts it. Reset is synchronous and active high.

Top module: `fifo_mark_rewind`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `rd_data` is 0.
- R2: Words come out in the order they were written. An accepted read (`rd_en` high while `empty` is 0) places the oldest word on `rd_data` at that clock edge. `rd_data` holds its value in every cycle without an accepted read.
- R3: After 512 accepted writes with no reads, `full` is 1. A write while `full` is 1 is dropped: the stored contents and the write position do not change.
- R4: A read while `empty` is 1 is dropped: `rd_data` keeps its value and `empty` stays 1.
- R5: `mark_rd` saves the current read position. `rewind_rd` moves the read position back to the saved one, so the words after that position are delivered again.
- R6: `mark_wr` saves the current write position. `rewind_wr` moves the write position back to the saved one, so later writes overwrite the words stored from that position onward.
- R7: `ptr_clear` sets the read position, the write position and both saved positions to zero, which leaves the FIFO empty.
- R8: When `rewind_rd` and `rd_en` are high in the same cycle, the read is dropped and `rd_data` holds. When `rewind_wr` and `wr_en` are high in the same cycle, the write is dropped.
- R9: `empty` and `full` are recomputed from the pointers after a restore. After all data has been read, a read restore clears `empty`. After a write restore to a saved position of zero, a full FIFO shows `full` = 0 and `empty` = 1.
- R10: Both positions wrap modulo 512, and an extra wrap bit tells full apart from empty. Data order stays correct over several laps of the storage.
- R11: `ptr_clear` takes priority over every other input in the same cycle, including reads, writes and restores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | 18 | Registered read word |
| empty | output | 1 | No words held |
| full | output | 1 | 512 words held |
| ptr_clear | input | 1 | Zero all four pointers |
| mark_rd | input | 1 | Save the read position |
| rewind_rd | input | 1 | Restore the saved read position |
| mark_wr | input | 1 | Save the write position |
| rewind_wr | input | 1 | Restore the saved write position |

## Verification
The assertions assume that a restore never moves a pointer past the other one. A saved read position must still lie within the data that is held, and a saved write position must lie at or after the current read position. If a restore broke this, occupancy would have no meaning. The stimulus keeps to this rule: it takes every mark while the data it refers to is still held, and it never reads past a write mark before restoring it. The assertions also take the strobes to be single-cycle pulses that are low during reset, and the bench drives them that way.

// File: rtl/fifo_mark_pkg.sv
package fifo_mark_pkg;

    // Per-pointer command bundle built by the top level
    typedef struct packed {
        logic clear;
        logic capture;
        logic restore;
        logic step;
    } ptr_cmd_t;

    // Resolved action on a live pointer, highest priority first
    typedef enum logic [1:0] {
        PTR_HOLD    = 2'd0,
        PTR_ZERO    = 2'd1,
        PTR_RESTORE = 2'd2,
        PTR_STEP    = 2'd3
    } ptr_op_e;

    function automatic ptr_op_e resolve_op(ptr_cmd_t cmd);
        ptr_op_e op;
        if (cmd.clear)        op = PTR_ZERO;
        else if (cmd.restore) op = PTR_RESTORE;
        else if (cmd.step)    op = PTR_STEP;
        else                  op = PTR_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/mark_ptr_unit.sv
module mark_ptr_unit
    import fifo_mark_pkg::*;
#(
    parameter int PW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  ptr_cmd_t      cmd,
    output logic [PW-1:0] ptr,
    output logic [PW-1:0] mark
);

    localparam logic [PW-1:0] ONE = PW'(1);

    ptr_op_e op;
    assign op = resolve_op(cmd);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else begin
            case (op)
                PTR_ZERO:    ptr <= '0;
                PTR_RESTORE: ptr <= mark;
                PTR_STEP:    ptr <= ptr + ONE;
                default:     ptr <= ptr;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            mark <= '0;
        end else if (cmd.capture) begin
            mark <= ptr;
        end
    end

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.clear |=> (ptr == '0) && (mark == '0));

    // R5
    restore_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.restore && !cmd.clear) |=> ptr == $past(mark));

    // R6
    capture_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.capture && !cmd.clear) |=> mark == $past(ptr));

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 512,
    parameter int AW    = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end

    // R2
    hold_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        !re |=> $stable(rdata));

endmodule

// File: rtl/fifo_flag_calc.sv
module fifo_flag_calc #(
    parameter int AW = 9
) (
    input  logic [AW:0] wptr,
    input  logic [AW:0] rptr,
    output logic        empty,
    output logic        full
);

    logic same_lap;
    logic same_slot;

    assign same_lap  = (wptr[AW] == rptr[AW]);
    assign same_slot = (wptr[AW-1:0] == rptr[AW-1:0]);
    assign empty     = same_slot && same_lap;
    assign full      = same_slot && !same_lap;

endmodule

// File: rtl/fifo_mark_rewind.sv
module fifo_mark_rewind
    import fifo_mark_pkg::*;
#(
    parameter int WIDTH = 18,
    parameter int DEPTH = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full,
    input  logic             ptr_clear,
    input  logic             mark_rd,
    input  logic             rewind_rd,
    input  logic             mark_wr,
    input  logic             rewind_wr
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wptr, wmark, rptr, rmark;
    logic          wr_go, rd_go;
    ptr_cmd_t      wcmd, rcmd;

    assign wr_go = wr_en && !full  && !rewind_wr && !ptr_clear;
    assign rd_go = rd_en && !empty && !rewind_rd && !ptr_clear;

    assign wcmd = '{clear: ptr_clear, capture: mark_wr, restore: rewind_wr, step: wr_go};
    assign rcmd = '{clear: ptr_clear, capture: mark_rd, restore: rewind_rd, step: rd_go};

    mark_ptr_unit #(.PW(PW)) u_wr_ptr (
        .clk  (clk),
        .rst  (rst),
        .cmd  (wcmd),
        .ptr  (wptr),
        .mark (wmark)
    );

    mark_ptr_unit #(.PW(PW)) u_rd_ptr (
        .clk  (clk),
        .rst  (rst),
        .cmd  (rcmd),
        .ptr  (rptr),
        .mark (rmark)
    );

    fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_go),
        .waddr (wptr[AW-1:0]),
        .wdata (wr_data),
        .re    (rd_go),
        .raddr (rptr[AW-1:0]),
        .rdata (rd_data)
    );

    fifo_flag_calc #(.AW(AW)) u_flags (
        .wptr  (wptr),
        .rptr  (rptr),
        .empty (empty),
        .full  (full)
    );

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rewind_wr && !ptr_clear) |=> wptr == $past(wptr));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && !rewind_rd && !ptr_clear) |=> $stable(rd_data) && $stable(rptr));

    // R8
    rewind_beats_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rewind_rd) |=> $stable(rd_data));

    // R10
    wrap_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_go && (wptr[AW-1:0] == AW'(DEPTH-1))) |=> wptr[AW-1:0] == '0);

    // R11
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_clear |=> empty && !full && $stable(rd_data));

endmodule

// File: tb/sim_fifo_mark_rewind.sv
module sim_fifo_mark_rewind;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [17:0] wr_data;
    logic [17:0] rd_data;
    logic        empty, full;
    logic        ptr_clear, mark_rd, rewind_rd, mark_wr, rewind_wr;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fifo_mark_rewind u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .empty     (empty),
        .full      (full),
        .ptr_clear (ptr_clear),
        .mark_rd   (mark_rd),
        .rewind_rd (rewind_rd),
        .mark_wr   (mark_wr),
        .rewind_wr (rewind_wr)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [17:0] act, logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(logic [17:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pop_expect(string req, logic [17:0] exp);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        check(req, rd_data, exp);
    endtask

    task automatic clear_ptrs;
        ptr_clear = 1'b1;
        tick();
        ptr_clear = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 empty", {17'd0, empty}, 18'd1);
        check("R1 full", {17'd0, full}, 18'd0);
        check("R1 rd_data", rd_data, 18'd0);
    endtask

    task automatic t_order;
        push(18'h00011); push(18'h3FFFF); push(18'h15555);
        push(18'h2AAAA); push(18'h00000);
        check("R2 not empty", {17'd0, empty}, 18'd0);
        pop_expect("R2 word0", 18'h00011);
        pop_expect("R2 word1", 18'h3FFFF);
        pop_expect("R2 word2", 18'h15555);
        pop_expect("R2 word3", 18'h2AAAA);
        pop_expect("R2 word4", 18'h00000);
        check("R2 empty after", {17'd0, empty}, 18'd1);
    endtask

    task automatic t_empty_read;
        push(18'h1234A);
        pop_expect("R4 setup", 18'h1234A);
        rd_en = 1'b1;
        tick(); tick();
        rd_en = 1'b0;
        check("R4 rd_data hold", rd_data, 18'h1234A);
        check("R4 still empty", {17'd0, empty}, 18'd1);
    endtask

    task automatic t_full;
        clear_ptrs();
        for (int i = 0; i < 512; i++) push(18'(i) ^ 18'h2A5A5);
        check("R3 full", {17'd0, full}, 18'd1);
        push(18'h3FFFF);
        check("R3 full held", {17'd0, full}, 18'd1);
        for (int i = 0; i < 512; i++) begin
            rd_en = 1'b1;
            tick();
            rd_en = 1'b0;
            if (i == 0 || i == 511) check("R3 content", rd_data, 18'(i) ^ 18'h2A5A5);
            else if (rd_data !== (18'(i) ^ 18'h2A5A5)) check("R3 content", rd_data, 18'(i) ^ 18'h2A5A5);
        end
        check("R3 empty after drain", {17'd0, empty}, 18'd1);
    endtask

    task automatic t_wrap;
        for (int lap = 0; lap < 3; lap++) begin
            for (int i = 0; i < 400; i++) push(18'(lap * 1000 + i + 7));
            for (int i = 0; i < 400; i++) begin
                rd_en = 1'b1;
                tick();
                rd_en = 1'b0;
                if (rd_data !== 18'(lap * 1000 + i + 7) || i == 399)
                    check("R10 wrap order", rd_data, 18'(lap * 1000 + i + 7));
            end
        end
        check("R10 empty", {17'd0, empty}, 18'd1);
    endtask

    task automatic t_reread;
        clear_ptrs();
        push(18'h0000A); push(18'h0000B); push(18'h0000C); push(18'h0000D);
        mark_rd = 1'b1; tick(); mark_rd = 1'b0;
        pop_expect("R5 first pass", 18'h0000A);
        pop_expect("R5 first pass", 18'h0000B);
        rewind_rd = 1'b1; tick(); rewind_rd = 1'b0;
        pop_expect("R5 replay", 18'h0000A);
        pop_expect("R5 replay", 18'h0000B);
        pop_expect("R5 replay", 18'h0000C);
        pop_expect("R5 replay", 18'h0000D);
        check("R9 empty before restore", {17'd0, empty}, 18'd1);
        rewind_rd = 1'b1; tick(); rewind_rd = 1'b0;
        check("R9 empty after restore", {17'd0, empty}, 18'd0);
        pop_expect("R9 replay after restore", 18'h0000A);
    endtask

    task automatic t_rewrite;
        clear_ptrs();
        push(18'h00101); push(18'h00102);
        mark_wr = 1'b1; tick(); mark_wr = 1'b0;
        push(18'h0DEAD); push(18'h0BEEF);
        rewind_wr = 1'b1; tick(); rewind_wr = 1'b0;
        push(18'h00201); push(18'h00202);
        pop_expect("R6 kept", 18'h00101);
        pop_expect("R6 kept", 18'h00102);
        pop_expect("R6 overwritten", 18'h00201);
        pop_expect("R6 overwritten", 18'h00202);
        check("R6 empty", {17'd0, empty}, 18'd1);
        clear_ptrs();
        mark_wr = 1'b1; tick(); mark_wr = 1'b0;
        for (int i = 0; i < 512; i++) push(18'(i));
        check("R9 full before restore", {17'd0, full}, 18'd1);
        rewind_wr = 1'b1; tick(); rewind_wr = 1'b0;
        check("R9 full after restore", {17'd0, full}, 18'd0);
        check("R9 empty after restore", {17'd0, empty}, 18'd1);
    endtask

    task automatic t_priority;
        clear_ptrs();
        push(18'h000A1); push(18'h000B2);
        mark_rd = 1'b1; tick(); mark_rd = 1'b0;
        pop_expect("R8 setup", 18'h000A1);
        rd_en = 1'b1; rewind_rd = 1'b1;
        tick();
        rd_en = 1'b0; rewind_rd = 1'b0;
        check("R8 read dropped", rd_data, 18'h000A1);
        pop_expect("R8 restored read", 18'h000A1);
        mark_wr = 1'b1; tick(); mark_wr = 1'b0;
        push(18'h000C3);
        wr_en = 1'b1; wr_data = 18'h3F00F; rewind_wr = 1'b1;
        tick();
        wr_en = 1'b0; rewind_wr = 1'b0;
        push(18'h000D4);
        pop_expect("R8 write side", 18'h000B2);
        pop_expect("R8 write dropped", 18'h000D4);
        check("R8 empty", {17'd0, empty}, 18'd1);
    endtask

    task automatic t_clear;
        clear_ptrs();
        push(18'h00E01); push(18'h00E02); push(18'h00E03);
        pop_expect("R11 setup", 18'h00E01);
        mark_rd = 1'b1; mark_wr = 1'b1; tick(); mark_rd = 1'b0; mark_wr = 1'b0;
        ptr_clear = 1'b1; wr_en = 1'b1; wr_data = 18'h3AAAA;
        rd_en = 1'b1; rewind_rd = 1'b1; rewind_wr = 1'b1;
        tick();
        ptr_clear = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rewind_rd = 1'b0; rewind_wr = 1'b0;
        check("R11 empty", {17'd0, empty}, 18'd1);
        check("R11 rd_data held", rd_data, 18'h00E01);
        push(18'h00F01); push(18'h00F02);
        pop_expect("R7 after clear", 18'h00F01);
        pop_expect("R7 after clear", 18'h00F02);
        rewind_rd = 1'b1; tick(); rewind_rd = 1'b0;
        pop_expect("R7 mark zeroed", 18'h00F01);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        ptr_clear = 1'b0; mark_rd = 1'b0; rewind_rd = 1'b0;
        mark_wr = 1'b0; rewind_wr = 1'b0;
        tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_order();
        t_empty_read();
        t_full();
        t_wrap();
        t_reread();
        t_rewrite();
        t_priority();
        t_clear();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule